// File: doc/BRIEF.md
# Floppy Sector Read Transfer Engine

This block is the read-sector path of a floppy disk controller. Once the host has loaded the sector register, it issues a read command. The engine then watches a pre-decoded stream from the disk side. That stream has three kinds of event: ID-field events, data-field events and index pulses. The engine searches for the ID field of the requested record. It then moves that record's data bytes, one at a time, into a host-visible data register, and raises a data-request flag for each byte.

The command word has three flags. A multi-record flag makes the engine step the sector register and carry on through consecutive records. An optional side-compare flag, with a side-select flag, restricts which ID fields can match. The outcome appears in a status byte and on a completion interrupt. The status byte reports busy, data request, lost data, data CRC error, record not found and the data-mark kind. The three error bits sit in positions 2 to 4, so a single mask of 0x1C tests for any failure.

Top module: `sector_read_engine`

## Requirements
- R1: After synchronous reset, `status`, `drq`, `intrq` and `sector_reg` are all zero.
- R2: A `sec_wr` pulse loads `sec_wdata` into `sector_reg` only while no command is running. A write during a command leaves `sector_reg` unchanged.
- R3: Status bits are: busy bit 0, data request bit 1, lost data bit 2, data CRC error bit 3, record not found bit 4, deleted data mark bit 5, and bits 7..6 always zero. One cycle after an accepted `cmd_go`, busy is 1, `intrq` is 0 and bits 2..5 are 0.
- R4: An ID field matches only when all of these hold: its track equals `head_track`, its sector equals `sector_reg`, and its CRC flag is 1. When the latched side-compare flag is 1, `id_side_lsb` must also equal the latched side-select flag. Data fields that arrive before a match transfer nothing.
- R5: Each accepted data byte appears on `data_out` with `drq` (status bit 1) set one cycle after its strobe. A host read (`host_rd`) in a cycle with no new byte clears `drq` on the next cycle.
- R6: If a byte arrives while `drq` is set and no host read happens in that cycle, lost data (bit 2) is set and the new byte replaces the old one in `data_out`.
- R7: The data CRC result travels with the last of the `BYTES_PER_SECTOR` byte strobes. If `df_crc_ok` is 0 there, bit 3 is set, the command ends and `intrq` rises.
- R8: If `INDEX_LIMIT` index pulses pass during a search with no match, bit 4 is set, the command ends and `intrq` rises.
- R9: The `df_deleted` value given with the data-field start is held in bit 5 (1 means deleted mark) until the next command.
- R10: In single-record mode the command ends after the last byte of one good record. `intrq` rises and `sector_reg` keeps its value.
- R11: In multi-record mode `sector_reg` increments after each good record. The command ends when the incremented value exceeds `SECTORS_PER_TRACK`; otherwise the engine searches for the next record.
- R12: `cmd_abort` ends any running command on the next cycle, with busy cleared and `intrq` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start a read command (accepted when idle) |
| cmd_multi | input | 1 | Multi-record flag |
| cmd_side_chk | input | 1 | Enable side comparison |
| cmd_side_sel | input | 1 | Expected side bit |
| cmd_abort | input | 1 | Force-interrupt: end the command now |
| sec_wr | input | 1 | Load the sector register |
| sec_wdata | input | 8 | Sector value to load |
| head_track | input | 8 | Track the head currently sits on |
| idx_pulse | input | 1 | Index pulse, one per revolution |
| id_vld | input | 1 | ID-field event strobe |
| id_track | input | 8 | ID-field track number |
| id_sector | input | 8 | ID-field sector number |
| id_side_lsb | input | 1 | Low bit of ID-field side number |
| id_crc_ok | input | 1 | ID-field CRC good |
| df_start | input | 1 | Data-field start strobe |
| df_deleted | input | 1 | Data mark is the deleted kind |
| df_vld | input | 1 | Data byte strobe |
| df_byte | input | 8 | Data byte |
| df_crc_ok | input | 1 | Data CRC good (sampled with the last byte) |
| host_rd | input | 1 | Host reads the data register |
| data_out | output | 8 | Data register |
| status | output | 8 | Status byte |
| drq | output | 1 | Data request |
| intrq | output | 1 | Command-completion interrupt |
| sector_reg | output | 8 | Sector register |

## Verification
Some rules are checked on every cycle by assertions:
- a byte strobe always raises the data request;
- a read with no new byte clears it;
- an unserviced byte always records lost data;
- busy never falls without the completion interrupt;
- the sector register only ever steps by one during a command;
- record-not-found only appears as the engine goes idle.

Other behaviour needs whole scenarios from the bench:
- ID fields rejected for track, sector, CRC or side, with the side ignored when comparison is off;
- the byte count and the CRC flag on the final byte;
- the index-pulse limit;
- the two-record run that stops just past the last sector of a track.

// File: rtl/sre_pkg.sv
package sre_pkg;

    localparam int ID_W = 8;

    localparam int SB_BUSY = 0;
    localparam int SB_DRQ  = 1;
    localparam int SB_LOST = 2;
    localparam int SB_CRC  = 3;
    localparam int SB_RNF  = 4;
    localparam int SB_MARK = 5;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEARCH,
        SQ_WAIT_DF,
        SQ_XFER
    } sre_state_e;

    typedef struct packed {
        logic [ID_W-1:0] track;
        logic [ID_W-1:0] sector;
        logic            side;
        logic            crc_ok;
    } sre_id_t;

    typedef struct packed {
        logic mark;
        logic rnf;
        logic crc;
        logic lost;
        logic drq;
        logic busy;
    } sre_flags_t;

    function automatic logic id_hit(sre_id_t id, logic [ID_W-1:0] want_trk,
                                    logic [ID_W-1:0] want_sec, logic chk, logic sel);
        return id.crc_ok && (id.track == want_trk) && (id.sector == want_sec)
               && (!chk || (id.side == sel));
    endfunction

    function automatic logic [7:0] pack_status(sre_flags_t f);
        logic [7:0] st;
        st          = '0;
        st[SB_BUSY] = f.busy;
        st[SB_DRQ]  = f.drq;
        st[SB_LOST] = f.lost;
        st[SB_CRC]  = f.crc;
        st[SB_RNF]  = f.rnf;
        st[SB_MARK] = f.mark;
        return st;
    endfunction

endpackage

// File: rtl/sre_id_match.sv
module sre_id_match
    import sre_pkg::*;
(
    input  sre_id_t         id,
    input  logic [ID_W-1:0] want_track,
    input  logic [ID_W-1:0] want_sector,
    input  logic            side_chk,
    input  logic            side_sel,
    output logic            hit
);
    always_comb hit = id_hit(id, want_track, want_sector, side_chk, side_sel);
endmodule

// File: rtl/sre_data_port.sv
module sre_data_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          host_rd,
    output logic [DW-1:0] data_q,
    output logic          drq_q,
    output logic          lost_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            drq_q  <= 1'b0;
            lost_q <= 1'b0;
        end else if (clr) begin
            drq_q  <= 1'b0;
            lost_q <= 1'b0;
        end else if (load) begin
            data_q <= din;
            drq_q  <= 1'b1;
            if (drq_q && !host_rd) lost_q <= 1'b1;
        end else if (host_rd) begin
            drq_q <= 1'b0;
        end
    end

    // R5
    byte_sets_drq_chk: assert property (@(posedge clk) disable iff (rst)
        load && !clr |=> drq_q);
    // R5
    read_clears_drq_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd && !load && !clr |=> !drq_q);
    // R6
    overrun_flags_lost_chk: assert property (@(posedge clk) disable iff (rst)
        load && drq_q && !host_rd && !clr |=> lost_q);
endmodule

// File: rtl/sre_seq.sv
module sre_seq
    import sre_pkg::*;
#(
    parameter int BYTES_PER_SECTOR  = 256,
    parameter int SECTORS_PER_TRACK = 16,
    parameter int INDEX_LIMIT       = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_go,
    input  logic            cmd_multi,
    input  logic            cmd_side_chk,
    input  logic            cmd_side_sel,
    input  logic            cmd_abort,
    input  logic            sec_wr,
    input  logic [ID_W-1:0] sec_wdata,
    input  logic            id_vld,
    input  logic            id_match,
    input  logic            idx_pulse,
    input  logic            df_start,
    input  logic            df_deleted,
    input  logic            df_vld,
    input  logic            df_crc_ok,
    output logic            busy,
    output logic            start,
    output logic            xfer_load,
    output logic            crc_err_q,
    output logic            rnf_q,
    output logic            mark_q,
    output logic            intrq_q,
    output logic [ID_W-1:0] sec_q,
    output logic            side_chk_q,
    output logic            side_sel_q
);
    localparam int BC_W = $clog2(BYTES_PER_SECTOR);
    localparam int IX_W = $clog2(INDEX_LIMIT + 1);
    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(BYTES_PER_SECTOR - 1);
    localparam logic [IX_W-1:0] LAST_IDX  = IX_W'(INDEX_LIMIT - 1);
    localparam logic [ID_W-1:0] SPT       = ID_W'(SECTORS_PER_TRACK);

    sre_state_e      state_q;
    logic            multi_q;
    logic [BC_W-1:0] byte_cnt;
    logic [IX_W-1:0] idx_cnt;

    always_comb begin
        busy      = (state_q != SQ_IDLE);
        start     = cmd_go && !cmd_abort && (state_q == SQ_IDLE);
        xfer_load = df_vld && !cmd_abort && (state_q == SQ_XFER);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            multi_q    <= 1'b0;
            side_chk_q <= 1'b0;
            side_sel_q <= 1'b0;
            sec_q      <= '0;
            byte_cnt   <= '0;
            idx_cnt    <= '0;
            crc_err_q  <= 1'b0;
            rnf_q      <= 1'b0;
            mark_q     <= 1'b0;
            intrq_q    <= 1'b0;
        end else if (cmd_abort) begin
            state_q <= SQ_IDLE;
            intrq_q <= 1'b1;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (sec_wr) sec_q <= sec_wdata;
                    if (cmd_go) begin
                        multi_q    <= cmd_multi;
                        side_chk_q <= cmd_side_chk;
                        side_sel_q <= cmd_side_sel;
                        crc_err_q  <= 1'b0;
                        rnf_q      <= 1'b0;
                        mark_q     <= 1'b0;
                        intrq_q    <= 1'b0;
                        idx_cnt    <= '0;
                        state_q    <= SQ_SEARCH;
                    end
                end
                SQ_SEARCH: begin
                    if (id_vld && id_match) begin
                        byte_cnt <= '0;
                        state_q  <= SQ_WAIT_DF;
                    end else if (idx_pulse) begin
                        if (idx_cnt == LAST_IDX) begin
                            rnf_q   <= 1'b1;
                            intrq_q <= 1'b1;
                            state_q <= SQ_IDLE;
                        end else begin
                            idx_cnt <= idx_cnt + 1'b1;
                        end
                    end
                end
                SQ_WAIT_DF: begin
                    if (df_start) begin
                        mark_q  <= df_deleted;
                        state_q <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (df_vld) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == LAST_BYTE) begin
                            if (!df_crc_ok) begin
                                crc_err_q <= 1'b1;
                                intrq_q   <= 1'b1;
                                state_q   <= SQ_IDLE;
                            end else if (multi_q) begin
                                sec_q   <= sec_q + 1'b1;
                                idx_cnt <= '0;
                                if (sec_q >= SPT) begin
                                    intrq_q <= 1'b1;
                                    state_q <= SQ_IDLE;
                                end else begin
                                    state_q <= SQ_SEARCH;
                                end
                            end else begin
                                intrq_q <= 1'b1;
                                state_q <= SQ_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R10 R12
    end_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> intrq_q);
    // R11
    sector_steps_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$stable(sec_q) |-> sec_q == $past(sec_q) + 1'b1);
    // R8
    rnf_only_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rnf_q) |-> !busy);
endmodule

// File: rtl/sector_read_engine.sv
module sector_read_engine
    import sre_pkg::*;
#(
    parameter int BYTES_PER_SECTOR  = 256,
    parameter int SECTORS_PER_TRACK = 16,
    parameter int INDEX_LIMIT       = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_go,
    input  logic       cmd_multi,
    input  logic       cmd_side_chk,
    input  logic       cmd_side_sel,
    input  logic       cmd_abort,
    input  logic       sec_wr,
    input  logic [7:0] sec_wdata,
    input  logic [7:0] head_track,
    input  logic       idx_pulse,
    input  logic       id_vld,
    input  logic [7:0] id_track,
    input  logic [7:0] id_sector,
    input  logic       id_side_lsb,
    input  logic       id_crc_ok,
    input  logic       df_start,
    input  logic       df_deleted,
    input  logic       df_vld,
    input  logic [7:0] df_byte,
    input  logic       df_crc_ok,
    input  logic       host_rd,
    output logic [7:0] data_out,
    output logic [7:0] status,
    output logic       drq,
    output logic       intrq,
    output logic [7:0] sector_reg
);
    sre_id_t    id_in;
    sre_flags_t flags;
    logic       hit, busy, start, xfer_load, crc_err, rnf, mark, lost;
    logic       side_chk_q, side_sel_q;

    always_comb begin
        id_in.track  = id_track;
        id_in.sector = id_sector;
        id_in.side   = id_side_lsb;
        id_in.crc_ok = id_crc_ok;
    end

    sre_id_match u_match (
        .id          (id_in),
        .want_track  (head_track),
        .want_sector (sector_reg),
        .side_chk    (side_chk_q),
        .side_sel    (side_sel_q),
        .hit         (hit)
    );

    sre_seq #(
        .BYTES_PER_SECTOR  (BYTES_PER_SECTOR),
        .SECTORS_PER_TRACK (SECTORS_PER_TRACK),
        .INDEX_LIMIT       (INDEX_LIMIT)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_go       (cmd_go),
        .cmd_multi    (cmd_multi),
        .cmd_side_chk (cmd_side_chk),
        .cmd_side_sel (cmd_side_sel),
        .cmd_abort    (cmd_abort),
        .sec_wr       (sec_wr),
        .sec_wdata    (sec_wdata),
        .id_vld       (id_vld),
        .id_match     (hit),
        .idx_pulse    (idx_pulse),
        .df_start     (df_start),
        .df_deleted   (df_deleted),
        .df_vld       (df_vld),
        .df_crc_ok    (df_crc_ok),
        .busy         (busy),
        .start        (start),
        .xfer_load    (xfer_load),
        .crc_err_q    (crc_err),
        .rnf_q        (rnf),
        .mark_q       (mark),
        .intrq_q      (intrq),
        .sec_q        (sector_reg),
        .side_chk_q   (side_chk_q),
        .side_sel_q   (side_sel_q)
    );

    sre_data_port #(.DW(8)) u_port (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .load    (xfer_load),
        .din     (df_byte),
        .host_rd (host_rd),
        .data_q  (data_out),
        .drq_q   (drq),
        .lost_q  (lost)
    );

    always_comb begin
        flags.busy = busy;
        flags.drq  = drq;
        flags.lost = lost;
        flags.crc  = crc_err;
        flags.rnf  = rnf;
        flags.mark = mark;
        status     = pack_status(flags);
    end
endmodule

// File: tb/sector_read_engine_bench.sv
module sector_read_engine_bench;
    localparam int NB   = 256;
    localparam int SPT  = 16;
    localparam int IDXL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_go = 0, cmd_multi = 0, cmd_side_chk = 0, cmd_side_sel = 0, cmd_abort = 0;
    logic sec_wr = 0;
    logic [7:0] sec_wdata = '0, head_track = 8'd7;
    logic idx_pulse = 0, id_vld = 0, id_side_lsb = 0, id_crc_ok = 0;
    logic [7:0] id_track = '0, id_sector = '0;
    logic df_start = 0, df_deleted = 0, df_vld = 0, df_crc_ok = 1;
    logic [7:0] df_byte = '0;
    logic host_rd = 0;
    logic [7:0] data_out, status, sector_reg;
    logic drq, intrq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sector_read_engine #(.BYTES_PER_SECTOR(NB), .SECTORS_PER_TRACK(SPT), .INDEX_LIMIT(IDXL))
    u_sector_read_engine (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_multi(cmd_multi),
        .cmd_side_chk(cmd_side_chk), .cmd_side_sel(cmd_side_sel), .cmd_abort(cmd_abort),
        .sec_wr(sec_wr), .sec_wdata(sec_wdata), .head_track(head_track),
        .idx_pulse(idx_pulse), .id_vld(id_vld), .id_track(id_track), .id_sector(id_sector),
        .id_side_lsb(id_side_lsb), .id_crc_ok(id_crc_ok), .df_start(df_start),
        .df_deleted(df_deleted), .df_vld(df_vld), .df_byte(df_byte), .df_crc_ok(df_crc_ok),
        .host_rd(host_rd), .data_out(data_out), .status(status), .drq(drq),
        .intrq(intrq), .sector_reg(sector_reg)
    );

    function automatic logic [7:0] exp_st(bit b, bit d, bit l, bit c, bit r, bit m);
        return {2'b00, m, r, c, l, d, b};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic load_sec(logic [7:0] v);
        sec_wr = 1; sec_wdata = v; tick; sec_wr = 0;
    endtask

    task automatic start_cmd(bit m, bit c, bit s);
        cmd_go = 1; cmd_multi = m; cmd_side_chk = c; cmd_side_sel = s;
        tick;
        cmd_go = 0;
    endtask

    task automatic send_id(logic [7:0] t, logic [7:0] s, bit sd, bit ok);
        id_vld = 1; id_track = t; id_sector = s; id_side_lsb = sd; id_crc_ok = ok;
        tick;
        id_vld = 0;
    endtask

    // one stray data field start plus one byte; nothing may be transferred
    task automatic stray_byte(string req);
        df_start = 1; tick; df_start = 0;
        df_vld = 1; df_byte = 8'h5A; tick; df_vld = 0;
        chk(req, drq, 0);
    endtask

    task automatic send_field(bit del, bit crc_ok, int skip_rd, output int bad);
        logic [7:0] b;
        bad = 0;
        df_start = 1; df_deleted = del; tick; df_start = 0;
        for (int i = 0; i < NB; i++) begin
            b = 8'($urandom);
            df_byte = b; df_vld = 1; df_crc_ok = (i == NB - 1) ? crc_ok : 1'b1;
            tick;
            df_vld = 0; df_crc_ok = 1;
            if (data_out !== b || drq !== 1'b1) bad++;
            if (i != skip_rd) begin
                host_rd = 1; tick; host_rd = 0;
                if (drq !== 1'b0) bad++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bad;
        logic [7:0] sec;
        bit sc, ss;
        void'($urandom(32'd4242));
        repeat (3) tick;
        rst = 0;
        tick;
        // R1
        chk("R1 status", status, 0);
        chk("R1 drq", drq, 0);
        chk("R1 intrq", intrq, 0);
        chk("R1 sector", sector_reg, 0);

        // single record, rejected IDs first, deleted mark
        load_sec(8'd5);
        chk("R2 load idle", sector_reg, 5);
        start_cmd(0, 0, 0);
        chk("R3 busy after go", status, exp_st(1, 0, 0, 0, 0, 0));
        chk("R3 intrq low", intrq, 0);
        load_sec(8'd9);
        chk("R2 write while busy ignored", sector_reg, 5);
        send_id(head_track + 8'd1, 8'd5, 0, 1);
        stray_byte("R4 track mismatch");
        send_id(head_track, 8'd6, 0, 1);
        stray_byte("R4 sector mismatch");
        send_id(head_track, 8'd5, 0, 0);
        stray_byte("R4 id crc bad");
        send_id(head_track, 8'd5, 1, 1);
        send_field(1, 1, -1, bad);
        chk("R5 bytes and drq", bad, 0);
        chk("R9 R10 status deleted", status, exp_st(0, 0, 0, 0, 0, 1));
        chk("R10 intrq", intrq, 1);
        chk("R10 sector kept", sector_reg, 5);

        // side comparison enabled
        load_sec(8'd2);
        start_cmd(0, 1, 1);
        send_id(head_track, 8'd2, 0, 1);
        stray_byte("R4 side mismatch");
        send_id(head_track, 8'd2, 1, 1);
        send_field(0, 1, -1, bad);
        chk("R4 side match bytes", bad, 0);
        chk("R9 status normal mark", status, exp_st(0, 0, 0, 0, 0, 0));

        // random records, random flags
        for (int k = 0; k < 4; k++) begin
            sec = 8'(1 + ($urandom % (SPT - 1)));
            sc = 1'($urandom);
            ss = 1'($urandom);
            load_sec(sec);
            start_cmd(0, sc, ss);
            send_id(head_track ^ 8'h10, sec, ss, 1);
            send_id(head_track, sec, sc ? ss : ~ss, 1);
            send_field(k[0], 1, -1, bad);
            chk("R4 R5 random record", bad, 0);
            chk("R10 random status", status, exp_st(0, 0, 0, 0, 0, k[0]));
        end

        // lost data
        load_sec(8'd3);
        start_cmd(0, 0, 0);
        send_id(head_track, 8'd3, 0, 1);
        send_field(0, 1, 10, bad);
        chk("R6 overwrite data", bad, 0);
        chk("R6 lost bit", status, exp_st(0, 0, 1, 0, 0, 0));

        // data CRC error
        start_cmd(0, 0, 0);
        chk("R3 errors cleared", status, exp_st(1, 0, 0, 0, 0, 0));
        send_id(head_track, 8'd3, 0, 1);
        send_field(0, 0, -1, bad);
        chk("R7 crc status", status, exp_st(0, 0, 0, 1, 0, 0));
        chk("R7 intrq", intrq, 1);

        // record not found
        start_cmd(0, 0, 0);
        for (int k = 0; k < IDXL - 1; k++) begin
            idx_pulse = 1; tick; idx_pulse = 0;
            send_id(head_track, 8'd4, 0, 1);
        end
        chk("R8 still searching", status, exp_st(1, 0, 0, 0, 0, 0));
        idx_pulse = 1; tick; idx_pulse = 0;
        chk("R8 rnf status", status, exp_st(0, 0, 0, 0, 1, 0));
        chk("R8 intrq", intrq, 1);

        // multi-record run across end of track
        load_sec(8'(SPT - 1));
        start_cmd(1, 0, 0);
        send_id(head_track, 8'(SPT - 1), 0, 1);
        send_field(0, 1, -1, bad);
        chk("R11 first record bytes", bad, 0);
        chk("R11 continues", status, exp_st(1, 0, 0, 0, 0, 0));
        chk("R11 sector step", sector_reg, SPT);
        send_id(head_track, 8'(SPT), 0, 1);
        send_field(1, 1, -1, bad);
        chk("R11 second record bytes", bad, 0);
        chk("R11 ended", status, exp_st(0, 0, 0, 0, 0, 1));
        chk("R11 past limit", sector_reg, SPT + 1);
        chk("R11 intrq", intrq, 1);

        // force interrupt during search
        load_sec(8'd1);
        start_cmd(0, 0, 0);
        chk("R3 intrq cleared", intrq, 0);
        send_id(head_track, 8'd9, 0, 1);
        cmd_abort = 1; tick; cmd_abort = 0;
        chk("R12 abort status", status, exp_st(0, 0, 0, 0, 0, 0));
        chk("R12 intrq", intrq, 1);
        start_cmd(0, 0, 0);
        chk("R12 R3 restart", status, exp_st(1, 0, 0, 0, 0, 0));
        cmd_abort = 1; tick; cmd_abort = 0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule